// File: doc/BRIEF.md
# Fault-Aware Issue Select with Criticality Detection

This block is the select stage of an out-of-order issue queue. Each cycle it looks at up to 32 queue entries, each with a ready flag, a 6-bit allocation stamp, a 4-bit fault/criticality field and the index of the execution unit it targets. It grants up to four of them to issue slots. A 2-bit policy input picks the ordering. The first ordering is pure age. The second puts entries predicted to violate timing ahead of the rest. The third puts entries that are both predicted faulty and marked critical ahead of the rest. Within each priority class, older entries win.

A second function estimates criticality. When a result tag is broadcast, the per-entry match lines from the wakeup array are counted. The broadcasting instruction is reported as critical when that count reaches a runtime threshold. The verdict goes out as a registered update so that the predictor can learn it.

Top module: `issue_select`

## Requirements
- R1: An entry is granted only when its `ready` bit is set and the `unit_avail` bit indexed by its 2-bit unit field is 1. A ready entry whose unit is unavailable yields its place to the next eligible entry.
- R2: At most 4 entries are granted per cycle. Slots fill from slot 0 upward with no gaps. The number granted is the smaller of 4 and the number of eligible entries.
- R3: Policy 0 orders entries by relative age `(alloc_stamp - age) mod 64`, where a larger value is older. Equal priority is broken in favour of the lower entry index.
- R4: Age ordering survives stamp wraparound. With `alloc_stamp`=2, an entry stamped 60 is older than one stamped 1.
- R5: Policy 1 ranks entries whose fault bit (field bit 3) is set above all others, and orders by age within each class.
- R6: Policy 2 ranks entries with both field bit 3 (fault) and bit 0 (critical) set above all others. A faulty entry that is not critical gets plain age order.
- R7: Policy 3 behaves exactly as policy 0.
- R8: Grants appear one clock after the inputs they were computed from. Slot k holds the entry with the (k+1)-th highest priority, and `gnt_vec` marks the granted entries.
- R9: One clock after a broadcast, `upd_vld` is 1, `upd_tag` echoes the broadcast tag, and `upd_crit` is 1 exactly when the number of set match lines is at least the threshold. With no broadcast, `upd_vld` is 0.
- R10: The threshold resets to 8. A write of a value from 1 to 32 takes effect from the next cycle. A write of 0 or of a value above 32 is ignored.
- R11: While reset is asserted, no grant, slot-valid or update output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Priority ordering select |
| alloc_stamp | input | 6 | Stamp the next allocated entry will receive |
| ready | input | 32 | Per-entry operands-ready flags |
| age_flat | input | 192 | Per-entry 6-bit allocation stamps |
| fld_flat | input | 128 | Per-entry 4-bit fault field (bit 3 fault, bits 2:1 stage, bit 0 critical) |
| unit_flat | input | 64 | Per-entry 2-bit target unit index |
| unit_avail | input | 4 | Unit can accept an instruction next cycle |
| bc_vld | input | 1 | Result broadcast valid |
| bc_tag | input | 6 | Tag of the broadcasting instruction |
| bc_match | input | 32 | Per-entry match lines for the broadcast |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 6 | New threshold value |
| gnt_vec | output | 32 | Granted entries |
| gnt_vld | output | 4 | Issue slot carries a grant |
| gnt_idx | output | 20 | Per-slot 5-bit granted entry index |
| upd_vld | output | 1 | Criticality update valid |
| upd_tag | output | 6 | Tag the update refers to |
| upd_crit | output | 1 | Broadcasting instruction judged critical |

## Verification
Some properties are checked by assertions on every cycle. Granted entries must have been eligible in the previous cycle, and the grant vector and slot-valid bits must agree in count. Slots must be packed from slot 0, and all slots must be full whenever at least four entries were eligible. The update valid and tag must follow the broadcast by one cycle. The actual ordering is left to the bench scenarios: age with wraparound, the two fault-aware classes, the lowest-index tie break, and the threshold comparison. So is threshold programming, including the rejected write values.

// File: rtl/isel_pkg.sv
package isel_pkg;
  localparam int AGE_W    = 6;
  localparam int FLD_W    = 4;
  localparam int FLT_BIT  = 3;
  localparam int CRIT_BIT = 0;
  localparam int KEY_W    = AGE_W + 1;

  typedef enum logic [1:0] {
    POL_AGE    = 2'd0,
    POL_FAULT  = 2'd1,
    POL_CRIT   = 2'd2,
    POL_AGE_B  = 2'd3
  } pol_e;
endpackage

// File: rtl/isel_key.sv
module isel_key
  import isel_pkg::*;
#(
  parameter int N  = 32,
  parameter int UW = 2,
  parameter int NU = 4
) (
  input  logic [1:0]         policy,
  input  logic [AGE_W-1:0]   alloc_stamp,
  input  logic [N-1:0]       ready,
  input  logic [N*AGE_W-1:0] age_flat,
  input  logic [N*FLD_W-1:0] fld_flat,
  input  logic [N*UW-1:0]    unit_flat,
  input  logic [NU-1:0]      unit_avail,
  output logic [N-1:0]       elig,
  output logic [N*KEY_W-1:0] key_flat
);
  pol_e pol;
  assign pol = pol_e'(policy);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [AGE_W-1:0] age_i;
    logic [FLD_W-1:0] fld_i;
    logic [UW-1:0]    unit_i;
    logic [AGE_W-1:0] rel_i;
    logic             cls_i;

    assign age_i  = age_flat[i*AGE_W +: AGE_W];
    assign fld_i  = fld_flat[i*FLD_W +: FLD_W];
    assign unit_i = unit_flat[i*UW +: UW];
    assign rel_i  = alloc_stamp - age_i;

    always_comb begin
      unique case (pol)
        POL_FAULT: cls_i = fld_i[FLT_BIT];
        POL_CRIT:  cls_i = fld_i[FLT_BIT] & fld_i[CRIT_BIT];
        default:   cls_i = 1'b0;
      endcase
    end

    assign elig[i] = ready[i] & unit_avail[unit_i];
    assign key_flat[i*KEY_W +: KEY_W] = {cls_i, rel_i};
  end
endmodule

// File: rtl/isel_pick.sv
module isel_pick
  import isel_pkg::*;
#(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]       cand,
  input  logic [N*KEY_W-1:0] keys,
  output logic               found,
  output logic [IW-1:0]      idx
);
  logic [KEY_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || keys[i*KEY_W +: KEY_W] > best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = keys[i*KEY_W +: KEY_W];
      end
    end
  end
endmodule

// File: rtl/isel_crit.sv
module isel_crit #(
  parameter int N        = 32,
  parameter int TAGW     = 6,
  parameter int CW       = 6,
  parameter int CRIT_DEF = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bc_vld,
  input  logic [TAGW-1:0] bc_tag,
  input  logic [N-1:0]    bc_match,
  input  logic            thr_we,
  input  logic [CW-1:0]   thr_wdata,
  output logic            upd_vld,
  output logic [TAGW-1:0] upd_tag,
  output logic            upd_crit
);
  logic [CW-1:0]   thr_q, thr_d;
  logic            thr_en;
  logic [CW-1:0]   mcount;
  logic            crit_d;
  logic            upd_en;

  always_comb begin
    mcount = '0;
    for (int i = 0; i < N; i++) mcount = mcount + CW'(bc_match[i]);
  end

  assign thr_en = thr_we && (thr_wdata != '0) && (int'(thr_wdata) <= N);
  assign thr_d  = thr_wdata;
  assign crit_d = bc_vld && (mcount >= thr_q);
  assign upd_en = bc_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= CW'(CRIT_DEF);
    else if (thr_en) thr_q <= thr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_vld  <= 1'b0;
      upd_crit <= 1'b0;
    end else begin
      upd_vld  <= bc_vld;
      upd_crit <= crit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upd_tag <= '0;
    else if (upd_en) upd_tag <= bc_tag;
  end
endmodule

// File: rtl/issue_select.sv
module issue_select
  import isel_pkg::*;
#(
  parameter int N        = 32,
  parameter int W        = 4,
  parameter int NU       = 4,
  parameter int TAGW     = 6,
  parameter int CRIT_DEF = 8,
  localparam int IW      = $clog2(N),
  localparam int UW      = $clog2(NU),
  localparam int CW      = $clog2(N + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         policy,
  input  logic [AGE_W-1:0]   alloc_stamp,
  input  logic [N-1:0]       ready,
  input  logic [N*AGE_W-1:0] age_flat,
  input  logic [N*FLD_W-1:0] fld_flat,
  input  logic [N*UW-1:0]    unit_flat,
  input  logic [NU-1:0]      unit_avail,
  input  logic               bc_vld,
  input  logic [TAGW-1:0]    bc_tag,
  input  logic [N-1:0]       bc_match,
  input  logic               thr_we,
  input  logic [CW-1:0]      thr_wdata,
  output logic [N-1:0]       gnt_vec,
  output logic [W-1:0]       gnt_vld,
  output logic [W*IW-1:0]    gnt_idx,
  output logic               upd_vld,
  output logic [TAGW-1:0]    upd_tag,
  output logic               upd_crit
);
  logic [N-1:0]       elig;
  logic [N*KEY_W-1:0] key_flat;
  logic [N-1:0]       rem [W+1];
  logic [W-1:0]       pk_found;
  logic [IW-1:0]      pk_idx [W];

  logic [N-1:0]       gnt_vec_d;
  logic [W-1:0]       gnt_vld_d;
  logic [W*IW-1:0]    gnt_idx_d;

  isel_key #(.N(N), .UW(UW), .NU(NU)) u_key (
    .policy      (policy),
    .alloc_stamp (alloc_stamp),
    .ready       (ready),
    .age_flat    (age_flat),
    .fld_flat    (fld_flat),
    .unit_flat   (unit_flat),
    .unit_avail  (unit_avail),
    .elig        (elig),
    .key_flat    (key_flat)
  );

  assign rem[0] = elig;

  for (genvar k = 0; k < W; k++) begin : g_slot
    isel_pick #(.N(N), .IW(IW)) u_pick (
      .cand  (rem[k]),
      .keys  (key_flat),
      .found (pk_found[k]),
      .idx   (pk_idx[k])
    );
    assign rem[k+1] = pk_found[k] ? (rem[k] & ~(N'(1) << pk_idx[k])) : rem[k];
  end

  always_comb begin
    gnt_vec_d = elig & ~rem[W];
    gnt_vld_d = pk_found;
    for (int k = 0; k < W; k++) gnt_idx_d[k*IW +: IW] = pk_idx[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_vec <= '0;
      gnt_vld <= '0;
      gnt_idx <= '0;
    end else begin
      gnt_vec <= gnt_vec_d;
      gnt_vld <= gnt_vld_d;
      gnt_idx <= gnt_idx_d;
    end
  end

  isel_crit #(.N(N), .TAGW(TAGW), .CW(CW), .CRIT_DEF(CRIT_DEF)) u_crit (
    .clk       (clk),
    .rst_n     (rst_n),
    .bc_vld    (bc_vld),
    .bc_tag    (bc_tag),
    .bc_match  (bc_match),
    .thr_we    (thr_we),
    .thr_wdata (thr_wdata),
    .upd_vld   (upd_vld),
    .upd_tag   (upd_tag),
    .upd_crit  (upd_crit)
  );
endmodule

// File: rtl/isel_chk.sv
module isel_chk #(
  parameter int N    = 32,
  parameter int W    = 4,
  parameter int TAGW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    elig,
  input logic [N-1:0]    gnt_vec,
  input logic [W-1:0]    gnt_vld,
  input logic            bc_vld,
  input logic [TAGW-1:0] bc_tag,
  input logic            upd_vld,
  input logic [TAGW-1:0] upd_tag
);
  AST_GNT_ELIG: assert property (@(posedge clk) disable iff (!rst_n) (gnt_vec & ~$past(elig)) == '0); // R1
  AST_GNT_CNT: assert property (@(posedge clk) disable iff (!rst_n) $countones(gnt_vec) == $countones(gnt_vld)); // R2
  AST_GNT_FULL: assert property (@(posedge clk) disable iff (!rst_n) ($countones($past(elig)) >= W) |-> (&gnt_vld)); // R2

  for (genvar k = 1; k < W; k++) begin : g_pack
    AST_SLOT_PACK: assert property (@(posedge clk) disable iff (!rst_n) gnt_vld[k] |-> gnt_vld[k-1]); // R2
  end

  AST_UPD_VLD: assert property (@(posedge clk) disable iff (!rst_n) upd_vld == $past(bc_vld)); // R9
  AST_UPD_TAG: assert property (@(posedge clk) disable iff (!rst_n) upd_vld |-> (upd_tag == $past(bc_tag))); // R9
  AST_RST_QUIET: assert property (@(posedge clk) !rst_n |-> (gnt_vld == '0 && !upd_vld)); // R11
endmodule

bind issue_select isel_chk #(.N(N), .W(W), .TAGW(TAGW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .elig    (elig),
  .gnt_vec (gnt_vec),
  .gnt_vld (gnt_vld),
  .bc_vld  (bc_vld),
  .bc_tag  (bc_tag),
  .upd_vld (upd_vld),
  .upd_tag (upd_tag)
);

// File: tb/sim_issue_select.sv
`timescale 1ns/1ps
module sim_issue_select;
  localparam int N = 32, W = 4, NU = 4, TAGW = 6, IW = 5, UW = 2, CW = 6;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [1:0]      policy;
  logic [5:0]      alloc_stamp;
  logic [N-1:0]    rdy;
  logic [5:0]      agev [N];
  logic [3:0]      fld [N];
  logic [UW-1:0]   unit [N];
  logic [NU-1:0]   unit_avail;
  logic            bc_vld, thr_we;
  logic [TAGW-1:0] bc_tag;
  logic [N-1:0]    bc_match;
  logic [CW-1:0]   thr_wdata;

  logic [N*6-1:0]  age_flat;
  logic [N*4-1:0]  fld_flat;
  logic [N*UW-1:0] unit_flat;
  always_comb
    for (int i = 0; i < N; i++) begin
      age_flat[i*6 +: 6]   = agev[i];
      fld_flat[i*4 +: 4]   = fld[i];
      unit_flat[i*UW +: UW] = unit[i];
    end

  logic [N-1:0]    gnt_vec;
  logic [W-1:0]    gnt_vld;
  logic [W*IW-1:0] gnt_idx;
  logic            upd_vld, upd_crit;
  logic [TAGW-1:0] upd_tag;

  issue_select u0 (
    .clk(clk), .rst_n(rst_n), .policy(policy), .alloc_stamp(alloc_stamp),
    .ready(rdy), .age_flat(age_flat), .fld_flat(fld_flat), .unit_flat(unit_flat),
    .unit_avail(unit_avail), .bc_vld(bc_vld), .bc_tag(bc_tag), .bc_match(bc_match),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .gnt_vec(gnt_vec), .gnt_vld(gnt_vld),
    .gnt_idx(gnt_idx), .upd_vld(upd_vld), .upd_tag(upd_tag), .upd_crit(upd_crit)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int thr_model = 8;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected grant packet {vec, vld, idx} from the requirement rules
  function automatic logic [63:0] exp_grant();
    logic [N-1:0]    left, vec;
    logic [W-1:0]    vld;
    logic [W*IW-1:0] idx;
    left = '0; vec = '0; vld = '0; idx = '0;
    for (int i = 0; i < N; i++) left[i] = rdy[i] && unit_avail[unit[i]];
    for (int k = 0; k < W; k++) begin
      int best = -1;
      int bkey = -1;
      for (int i = 0; i < N; i++) begin
        if (left[i]) begin
          int cls, key;
          logic [5:0] rel;
          rel = alloc_stamp - agev[i];
          cls = (policy == 2'd1) ? int'(fld[i][3]) :
                (policy == 2'd2) ? int'(fld[i][3] & fld[i][0]) : 0;
          key = cls * 64 + int'(rel);
          if (key > bkey) begin bkey = key; best = i; end
        end
      end
      if (best >= 0) begin
        vld[k] = 1'b1;
        idx[k*IW +: IW] = IW'(best);
        vec[best] = 1'b1;
        left[best] = 1'b0;
      end
    end
    return {8'd0, vec, vld, idx};
  endfunction

  task automatic clear();
    rdy = '0; policy = 2'd0; alloc_stamp = '0; unit_avail = '1;
    bc_vld = 0; bc_tag = '0; bc_match = '0; thr_we = 0; thr_wdata = '0;
    for (int i = 0; i < N; i++) begin agev[i] = '0; fld[i] = '0; unit[i] = '0; end
  endtask

  task automatic step(input string req);
    logic [63:0] eg;
    bit ebc, ecrit;
    logic [TAGW-1:0] etag;
    eg = exp_grant();
    ebc = bc_vld; etag = bc_tag;
    ecrit = bc_vld && ($countones(bc_match) >= thr_model);
    @(posedge clk); #1;
    chk({8'd0, gnt_vec, gnt_vld, gnt_idx} == eg, req, {8'd0, gnt_vec, gnt_vld, gnt_idx}, eg);
    chk(upd_vld == ebc, "R9", 64'(upd_vld), 64'(ebc));
    if (ebc) chk({upd_tag, upd_crit} == {etag, ecrit}, req, 64'({upd_tag, upd_crit}), 64'({etag, ecrit}));
    if (thr_we && thr_wdata >= 1 && thr_wdata <= 32) thr_model = int'(thr_wdata);
    bc_vld = 0; thr_we = 0;
  endtask

  task automatic bcast(input int cnt, input string req);
    bc_vld = 1; bc_tag = 6'(cnt + 3);
    bc_match = (cnt >= 32) ? '1 : N'((64'd1 << cnt) - 1);
    step(req);
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clear();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(gnt_vld == '0 && gnt_vec == '0 && !upd_vld, "R11", {gnt_vec, gnt_vld, upd_vld}, 64'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    // R3: age order, tie broken by lower index
    clear(); alloc_stamp = 6'd40;
    rdy[5] = 1; agev[5] = 6'd30;
    rdy[9] = 1; agev[9] = 6'd10;
    rdy[2] = 1; agev[2] = 6'd30;
    rdy[20] = 1; agev[20] = 6'd39;
    rdy[21] = 1; agev[21] = 6'd35;
    step("R3");
    // R4: wraparound
    clear(); alloc_stamp = 6'd2;
    rdy[0] = 1; agev[0] = 6'd1;
    rdy[7] = 1; agev[7] = 6'd60;
    step("R4");
    // R5: faulty first
    clear(); policy = 2'd1; alloc_stamp = 6'd50;
    rdy[1] = 1; agev[1] = 6'd0;
    rdy[3] = 1; agev[3] = 6'd49; fld[3] = 4'b1000;
    rdy[4] = 1; agev[4] = 6'd45; fld[4] = 4'b1010;
    step("R5");
    // R6: faulty but not critical stays in age order; faulty and critical jumps ahead
    clear(); policy = 2'd2; alloc_stamp = 6'd50;
    rdy[1] = 1; agev[1] = 6'd0;
    rdy[3] = 1; agev[3] = 6'd49; fld[3] = 4'b1000;
    rdy[4] = 1; agev[4] = 6'd45; fld[4] = 4'b1001;
    rdy[6] = 1; agev[6] = 6'd47; fld[6] = 4'b0001;
    rdy[8] = 1; agev[8] = 6'd20;
    step("R6");
    // R7: policy 3 ignores fault bits
    policy = 2'd3; step("R7");
    // R1: masked unit yields slot
    clear(); alloc_stamp = 6'd30;
    for (int i = 0; i < 6; i++) begin rdy[i] = 1; agev[i] = 6'(i); unit[i] = UW'(i % 4); end
    unit_avail = 4'b1101;
    step("R1");
    // R2: few eligible, then none
    clear(); rdy[12] = 1; step("R2");
    clear(); step("R2");
    // R2/R8: many eligible, only four granted in priority order
    clear(); alloc_stamp = 6'd63; rdy = '1;
    for (int i = 0; i < N; i++) agev[i] = 6'(i * 7);
    step("R8");
    // R9/R10: default threshold 8
    clear();
    bcast(8, "R10"); bcast(7, "R10");
    thr_we = 1; thr_wdata = 6'd0; step("R10");
    bcast(8, "R10"); bcast(7, "R10");
    thr_we = 1; thr_wdata = 6'd33; step("R10");
    bcast(8, "R10"); bcast(7, "R10");
    thr_we = 1; thr_wdata = 6'd1; step("R10");
    bcast(1, "R10"); bcast(0, "R9");
    thr_we = 1; thr_wdata = 6'd32; step("R10");
    bcast(32, "R10"); bcast(31, "R10");

    // Random mix over all rules
    for (int c = 0; c < 600; c++) begin
      policy = 2'($urandom);
      alloc_stamp = 6'($urandom);
      rdy = N'($urandom) & N'($urandom | $urandom);
      unit_avail = 4'($urandom) | 4'($urandom);
      for (int i = 0; i < N; i++) begin
        agev[i] = 6'($urandom); fld[i] = 4'($urandom); unit[i] = UW'($urandom);
      end
      bc_vld = 1'($urandom); bc_tag = 6'($urandom);
      bc_match = N'($urandom) & N'($urandom);
      if (($urandom % 8) == 0) begin thr_we = 1; thr_wdata = 6'($urandom % 40); end
      step((c % 2 == 0) ? "R3" : "R5");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule